// File: doc/BRIEF.md
# SONET A1/A2 Framing Inserter with Error Injection

This block sits in the transmit byte path of an STS-12 stream and writes the framing bytes into it. Each frame starts with twelve A1 slots followed by twelve A2 slots. When insertion is on, those slots carry the nominal framing values 0xF6 (A1) and 0x28 (A2) in place of whatever arrived on the input. Every other byte passes through untouched. A flag travels with every output byte and marks the framing slots.

For testing downstream framers, the block can corrupt the pattern. Only two bytes are corrupted: the last A1 slot of a frame and the first A2 slot. Each takes a programmed value. A burst of corruption lasts for a programmed number of frames. A count of zero means the burst runs until the error enable is dropped. Once a limited burst has run out, the block does not corrupt again until the enable has been cleared and set once more. Insertion can also be switched off completely, so that the framing slots carry the incoming bytes.

Bytes enter and leave on a valid/ready stream with a single register stage. The frame grid is anchored by a start-of-frame marker on the input, which travels with the byte.

Top module: `sonet_a1a2_inserter`

## Requirements
- R1: After reset, `out_valid` and `burst_active` are low and `in_ready` is high.
- R2: With `ins_en` high and no burst active, positions 0 to 11 of a frame leave as 0xF6 and positions 12 to 23 leave as 0x28. Position 0 is the accepted byte that has `in_sof` high. `out_fslot` is high exactly on positions 0 to 23.
- R3: While a burst is active and `ins_en` is high, position 11 leaves as `a1_err_val` and position 12 leaves as `a2_err_val`. All other framing positions keep 0xF6 and 0x28.
- R4: A burst starts at the first frame boundary after `err_en` rises. A frame boundary is an accepted byte with `in_sof` high, and it must be accepted at least one cycle after the cycle in which `err_en` is first high. `burst_active` goes high in the cycle after that boundary and rises at no other time.
- R5: With a nonzero `err_frames` value N, sampled when the burst starts, exactly N consecutive frames are corrupted, beginning with the boundary frame. `burst_active` drops in the cycle after the N-th following boundary.
- R6: After a limited burst ends with `err_en` still high, no further corruption occurs until `err_en` has been low for at least one cycle and then high again.
- R7: With `err_frames` equal to zero, the burst continues over any number of frames. Dropping `err_en` clears `burst_active` in the next cycle, and bytes accepted after that cycle are not corrupted.
- R8: With `ins_en` low, every byte passes through unchanged, including the framing positions. `out_fslot` still marks positions 0 to 23, and burst timing continues to run.
- R9: `in_ready` equals `!out_valid || out_ready`. A byte accepted in one cycle is presented on the output in the next cycle. Output data, flag and marker stay stable while `out_valid` is high and `out_ready` is low. Byte order is preserved.
- R10: Bytes accepted after reset and before the first `in_sof`, and bytes at positions 24 and beyond, are not framing slots. They pass through unchanged with `out_fslot` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Framing insertion on (1) or bypass (0) |
| err_en | input | 1 | Error-insert enable; a rising edge arms a burst |
| err_frames | input | CNT_W | Burst length in frames; 0 means continuous |
| a1_err_val | input | 8 | Value for the last A1 slot during a burst |
| a2_err_val | input | 8 | Value for the first A2 slot during a burst |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is position 0 of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is position 0 of a frame |
| out_fslot | output | 1 | Output byte occupies a framing slot |
| burst_active | output | 1 | A corruption burst is in progress |

## Verification
Each accepted byte is due on the output one cycle after the edge that takes it. It then stays there until the downstream handshake. The bench therefore computes the expected byte at the moment of acceptance, queues it, and compares it only when the output handshake occurs. `burst_active` is due one cycle after a frame boundary or after `err_en` drops. The reference model advances its burst state at the same edge and is compared with the port every cycle. All inputs are driven on the falling edge and all samples are taken just after it, so each check sees settled values of the current cycle.

// File: rtl/sonet_frm_pkg.sv
package sonet_frm_pkg;
  localparam logic [7:0] A1_NOMINAL = 8'hF6;
  localparam logic [7:0] A2_NOMINAL = 8'h28;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_A1   = 2'd1,
    SLOT_A2   = 2'd2
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic       hit_pt;   // the single corruptible slot of its group
  } slot_info_t;

  typedef struct packed {
    logic       sof;
    logic       fslot;
    logic [7:0] data;
  } out_beat_t;
endpackage

// File: rtl/frm_slot_tracker.sv
module frm_slot_tracker
  import sonet_frm_pkg::*;
#(
  parameter int GRP = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       sof,
  output slot_info_t info
);
  localparam int PW = $clog2(2 * GRP + 1);
  localparam logic [PW-1:0] POS_END  = PW'(2 * GRP);
  localparam logic [PW-1:0] POS_GRP  = PW'(GRP);
  localparam logic [PW-1:0] POS_LAST = PW'(GRP - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] cur;

  assign cur = sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= POS_END;
    end else if (take) begin
      pos_q <= (cur < POS_END) ? cur + PW'(1) : POS_END;
    end
  end

  always_comb begin
    info.kind   = SLOT_NONE;
    info.hit_pt = 1'b0;
    if (cur < POS_GRP) begin
      info.kind   = SLOT_A1;
      info.hit_pt = (cur == POS_LAST);
    end else if (cur < POS_END) begin
      info.kind   = SLOT_A2;
      info.hit_pt = (cur == POS_GRP);
    end
  end
endmodule

// File: rtl/frm_burst_ctrl.sv
module frm_burst_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_en,
  input  logic             boundary,
  input  logic [CNT_W-1:0] frames,
  output logic             active
);
  logic             en_q;
  logic             armed_q;
  logic             endless_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      armed_q   <= 1'b0;
      active    <= 1'b0;
      endless_q <= 1'b0;
      left_q    <= '0;
    end else begin
      en_q <= err_en;
      if (!err_en) begin
        armed_q   <= 1'b0;
        active    <= 1'b0;
        endless_q <= 1'b0;
      end else begin
        armed_q <= (armed_q && !boundary) || !en_q;
        if (boundary && armed_q) begin
          active    <= 1'b1;
          endless_q <= (frames == '0);
          left_q    <= frames;
        end else if (boundary && active && !endless_q) begin
          if (left_q == CNT_W'(1)) active <= 1'b0;
          left_q <= left_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/frm_byte_sel.sv
module frm_byte_sel
  import sonet_frm_pkg::*;
(
  input  logic       ins_en,
  input  slot_info_t info,
  input  logic       corrupt,
  input  logic [7:0] a1_val,
  input  logic [7:0] a2_val,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       fslot
);
  always_comb begin
    fslot = (info.kind != SLOT_NONE);
    dout  = din;
    if (ins_en) begin
      unique case (info.kind)
        SLOT_A1: dout = (corrupt && info.hit_pt) ? a1_val : A1_NOMINAL;
        SLOT_A2: dout = (corrupt && info.hit_pt) ? a2_val : A2_NOMINAL;
        default: dout = din;
      endcase
    end
  end
endmodule

// File: rtl/sonet_a1a2_inserter.sv
module sonet_a1a2_inserter
  import sonet_frm_pkg::*;
#(
  parameter int GRP   = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             err_en,
  input  logic [CNT_W-1:0] err_frames,
  input  logic [7:0]       a1_err_val,
  input  logic [7:0]       a2_err_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_fslot,
  output logic             burst_active
);
  slot_info_t info;
  out_beat_t  beat_d, beat_q;
  logic       take;
  logic [7:0] sel_data;
  logic       sel_fslot;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  frm_slot_tracker #(.GRP(GRP)) u_track (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .sof  (in_sof),
    .info (info)
  );

  frm_burst_ctrl #(.CNT_W(CNT_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_en  (err_en),
    .boundary(take && in_sof),
    .frames  (err_frames),
    .active  (burst_active)
  );

  frm_byte_sel u_sel (
    .ins_en (ins_en),
    .info   (info),
    .corrupt(burst_active),
    .a1_val (a1_err_val),
    .a2_val (a2_err_val),
    .din    (in_data),
    .dout   (sel_data),
    .fslot  (sel_fslot)
  );

  assign beat_d = '{sof: in_sof, fslot: sel_fslot, data: sel_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      beat_q    <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        beat_q    <= beat_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_data  = beat_q.data;
  assign out_sof   = beat_q.sof;
  assign out_fslot = beat_q.fslot;
endmodule

module sonet_a1a2_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       err_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_fslot,
  input logic       burst_active
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fslot)));

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  a_r4_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active) |-> $past(in_valid && in_ready && in_sof && err_en));

  a_r7_drop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !err_en |=> !burst_active);

  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind sonet_a1a2_inserter sonet_a1a2_checker u_chk (
  .clk(clk), .rst_n(rst_n), .err_en(err_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_sof(in_sof), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_fslot(out_fslot),
  .burst_active(burst_active)
);

// File: tb/sim_sonet_a1a2_inserter.sv
`timescale 1ns/1ps
module sim_sonet_a1a2_inserter;
  localparam int GRP = 12;
  localparam int CNT_W = 8;
  localparam int FLEN = 36;
  localparam logic [7:0] E1 = 8'h5A;
  localparam logic [7:0] E2 = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_en = 1'b0, err_en = 1'b0;
  logic [CNT_W-1:0] err_frames = '0;
  logic [7:0] a1_err_val = E1, a2_err_val = E2;
  logic in_valid = 1'b0, in_ready, in_sof = 1'b0, out_valid, out_ready = 1'b0;
  logic [7:0] in_data = '0, out_data;
  logic out_sof, out_fslot, burst_active;

  always #10 clk = ~clk;

  sonet_a1a2_inserter #(.GRP(GRP), .CNT_W(CNT_W)) u0 (.*);

  // next-cycle control values
  logic c_ins = 1'b0, c_err = 1'b0;
  logic [CNT_W-1:0] c_frames = '0;
  logic force_idle = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int bidx = FLEN - 4;
  int opos = 99;
  int corr = 0;

  // reference model
  bit m_en_q = 0, m_pend = 0, m_act = 0, m_cont = 0;
  int m_rem = 0, m_pos = 2 * GRP;
  logic [9:0] q_exp[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(output bit sof_taken);
    logic [7:0] e_data;
    int cur;
    bit e_fs, bnd, tk;
    string tag;
    @(negedge clk);
    ins_en = c_ins; err_en = c_err; err_frames = c_frames;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_valid  = force_idle ? 1'b0 : (lfsr[0] | lfsr[3]);
    out_ready = force_idle ? 1'b1 : (lfsr[5] | lfsr[9]);
    in_data   = 8'(bidx * 7 + 1);
    in_sof    = (bidx == 0);
    #1;
    chk(in_ready == (!out_valid || out_ready), "R9 ready", in_ready, !out_valid || out_ready);
    chk(burst_active == m_act, "R4/R5/R6/R7 burst_active", burst_active, m_act);
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) chk(0, "R9 unexpected output", out_data, 0);
      else begin
        logic [9:0] e;
        string t;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        chk({out_sof, out_fslot, out_data} == e, t, {out_sof, out_fslot, out_data}, e);
      end
      opos = out_sof ? 0 : opos + 1;
      if (opos == GRP && out_data == E2) corr++;
    end
    tk = in_valid && in_ready;
    bnd = tk && in_sof;
    if (tk) begin
      cur = in_sof ? 0 : m_pos;
      e_fs = (cur < 2 * GRP);
      e_data = in_data;
      tag = "R10 passthrough";
      if (e_fs) tag = "R2 framing byte";
      if (!ins_en) tag = "R8 bypass";
      else if (cur < GRP) begin
        e_data = (cur == GRP - 1 && m_act) ? a1_err_val : 8'hF6;
        if (cur == GRP - 1 && m_act) tag = "R3 A1 corruption";
      end else if (cur < 2 * GRP) begin
        e_data = (cur == GRP && m_act) ? a2_err_val : 8'h28;
        if (cur == GRP && m_act) tag = "R3 A2 corruption";
      end
      q_exp.push_back({in_sof, e_fs, e_data});
      q_tag.push_back(tag);
      m_pos = (cur < 2 * GRP) ? cur + 1 : cur;
      bidx = (bidx + 1) % FLEN;
    end
    if (!err_en) begin
      m_pend = 0; m_act = 0; m_cont = 0;
    end else begin
      bit rise;
      rise = !m_en_q;
      if (bnd && m_pend) begin
        m_act = 1; m_cont = (err_frames == 0); m_rem = err_frames;
      end else if (bnd && m_act && !m_cont) begin
        if (m_rem == 1) m_act = 0;
        m_rem--;
      end
      m_pend = (m_pend && !bnd) || rise;
    end
    m_en_q = err_en;
    sof_taken = bnd;
  endtask

  task automatic run_frames(input int n);
    int got = 0;
    bit s;
    while (got < n) begin
      step(s);
      if (s) got++;
    end
  endtask

  task automatic idle(input int n);
    bit s;
    for (int i = 0; i < n; i++) step(s);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(burst_active == 0, "R1 burst_active after reset", burst_active, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
    c_ins = 1;
    run_frames(3);                       // R2, R10
    c_frames = 3; c_err = 1; corr = 0;
    run_frames(7);
    idle(40);
    chk(corr == 3, "R5 corrupted frame count", corr, 3);
    run_frames(3); idle(40);
    chk(corr == 3, "R6 no re-arm while held", corr, 3);
    c_err = 0; idle(3); c_frames = 1; c_err = 1;
    run_frames(3); idle(40);
    chk(corr == 4, "R6 re-arm after clear/set", corr, 4);
    c_err = 0; c_frames = 0; idle(3); c_err = 1;
    run_frames(6);
    chk(burst_active == 1, "R7 continuous burst", burst_active, 1);
    base = corr;
    chk(base >= 8, "R7 frames corrupted continuously", base, 8);
    c_err = 0; idle(2);
    chk(burst_active == 0, "R7 cleared", burst_active, 0);
    c_ins = 0; c_err = 1; c_frames = 2;
    run_frames(4);                       // R8
    c_ins = 1;
    run_frames(1);
    force_idle = 1; idle(5);
    chk(q_exp.size() == 0, "R9 all bytes delivered", q_exp.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule